// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane LED Modulator

This block drives 32 LED channels through a daisy chain of external serial-in, parallel-out shift registers. It uses binary code modulation. Four adjacent channels make up one four-colour (red, green, blue, white) logical output, so the chain serves 8 logical outputs. A simple write port stores one 16-bit right-aligned brightness value per channel. Only the upper 14 bits of each value take part in modulation.

Once per frame the stored values are rearranged into 14 bit-planes of 32 bits each. Each period works on one plane and has two phases. In the data phase the plane is shifted out, latched into the storage registers with a single strobe pulse, and then held for a time weighted by the plane's bit position. A short reset phase follows, in which a one-cycle pulse clears the shift register. Every data phase has the same fixed shift-and-latch section, and every reset phase has the same length. This keeps the frame period and the relative duty cycle constant.

New brightness values reach the display only when the plane index wraps from the last plane back to plane 0. A frame therefore never shows a mix of old and new values. The timer step is one clock cycle, and the serial clock runs at half the clock rate.

Top module: `bcm_led_driver`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` as the brightness of channel `wr_addr` (0..31) on that clock edge. Channels 4k..4k+3 form logical output k.
- R2: Bit j of plane i equals bit i+2 of channel j's stored value. Bits 1:0 of every value are ignored, so a value of 16'h0003 produces zeros in every plane and 16'hFFFF produces ones in every plane.
- R3: Each data phase sends exactly 32 bits. `sck` is high on data-phase cycles 1, 3, …, 63 and `sdo` is stable while `sck` is high. Serial bit b (b = 0..31) carries channel 15-b for b < 16 and channel 47-b for b ≥ 16. This is low half first, high half second, and the most significant bit first within each half.
- R4: `strobe` is a one-cycle high pulse on data-phase cycle STB_AT (default 66), after all 32 serial clocks, and never coincides with `sck`.
- R5: The data phase for plane i lasts FIX_CYC + BASE_CYC·2^i cycles (defaults 68 and 1), and the reset phase lasts RST_CYC cycles (default 4). The distance between successive strobes is therefore FIX_CYC + RST_CYC + BASE_CYC·2^i, where i is the earlier strobe's plane.
- R6: The plane index goes 0, 1, …, 13 in turn, advances at the end of each data phase and wraps from 13 to 0.
- R7: Stored brightness is copied into the plane buffer only at the wrap from plane 13 to plane 0. All 14 planes of a frame come from one snapshot, even when writes arrive in the middle of the frame.
- R8: `clr_n` is low for exactly one cycle, the first cycle of each reset phase, and high at all other times. The next strobe follows the clear by RST_CYC + STB_AT cycles.
- R9: During reset and right after it, `sck` and `strobe` are low and `clr_n` is high. The planes start at zero, so frame 0 shows all zeros, and the first data phase is for plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Brightness write strobe |
| wr_addr | input | 5 | Channel written |
| wr_data | input | 16 | Right-aligned brightness value |
| sdo | output | 1 | Serial data to the shift register chain |
| sck | output | 1 | Serial clock; the chain samples on its rising edge |
| strobe | output | 1 | Storage register latch pulse, active high |
| clr_n | output | 1 | Shift register clear pulse, active low |

## Verification
The bench rebuilds every latched 32-bit word from the serial stream. It checks these words across three frames: an all-zero frame after reset, a frame loaded with a first value set, and a frame loaded with a second set that was written while the previous frame was still being shown. If the bit ordering were reversed or the halves were swapped, channels would land in the wrong places. If a write were let through before the wrap, frame 1 would show a mix of both sets. If the wrong bit slice were taken, the value 16'h0003 would light plane 0 and 16'h8000 would show up below plane 13. The bench also measures every strobe-to-strobe distance, including the long gap at the wrap from 13 to 0, and the distance from each clear to the next strobe. An off-by-one in the phase counter or a wrong weight shift would break the binary weighting, and a latch placed too early would arrive before the 32nd clock.

// File: rtl/bcm_led_pkg.sv
package bcm_led_pkg;
  typedef enum logic {
    PH_DATA = 1'b0,
    PH_RST  = 1'b1
  } phase_t;
endpackage

// File: rtl/bcm_plane_store.sv
module bcm_plane_store #(
  parameter int NCH   = 32,
  parameter int NBITS = 14,
  parameter int INW   = 16,
  parameter int AW    = 5,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [INW-1:0]   wr_data,
  input  logic             load,
  input  logic [IW-1:0]    sel,
  output logic [NCH-1:0]   plane
);
  localparam int LSB = INW - NBITS;

  logic [NBITS-1:0] bri_q [NCH];
  logic [NCH-1:0]   pl_q  [NBITS];
  logic [NCH-1:0]   pl_d  [NBITS];
  logic             unused_low;

  assign unused_low = ^wr_data[LSB-1:0];

  for (genvar j = 0; j < NCH; j++) begin : g_chan
    logic we;
    assign we = wr_en && (wr_addr == AW'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bri_q[j] <= '0;
      else if (we) bri_q[j] <= wr_data[INW-1:LSB];
    end
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
      assign pl_d[i][j] = bri_q[j][i];
    end
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pl_q[i] <= '0;
      else if (load) pl_q[i] <= pl_d[i];
    end
  end

  assign plane = pl_q[sel];
endmodule

// File: rtl/bcm_phase_seq.sv
module bcm_phase_seq
  import bcm_led_pkg::*;
#(
  parameter int NBITS    = 14,
  parameter int FIX_CYC  = 68,
  parameter int RST_CYC  = 4,
  parameter int BASE_CYC = 1,
  parameter int CW       = 14,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output phase_t        ph,
  output logic [CW-1:0] cnt,
  output logic [IW-1:0] idx,
  output logic          load
);
  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d, phase_len;
  logic [IW-1:0] idx_q, idx_d;
  logic          last, adv, wrap;

  always_comb begin
    phase_len = CW'(FIX_CYC) + (CW'(BASE_CYC) << idx_q);
    if (ph_q == PH_DATA) last = (cnt_q == phase_len - CW'(1));
    else                 last = (cnt_q == CW'(RST_CYC - 1));
    cnt_d = last ? '0 : cnt_q + CW'(1);
    ph_d  = ph_q;
    if (last) ph_d = (ph_q == PH_DATA) ? PH_RST : PH_DATA;
    wrap  = (idx_q == IW'(NBITS - 1));
    adv   = last && (ph_q == PH_DATA);
    idx_d = wrap ? '0 : idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (adv) idx_q <= idx_d;
    end
  end

  assign ph   = ph_q;
  assign cnt  = cnt_q;
  assign idx  = idx_q;
  assign load = adv && wrap;
endmodule

// File: rtl/bcm_serial_out.sv
module bcm_serial_out
  import bcm_led_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int STB_AT = 66,
  parameter int CW     = 14
) (
  input  phase_t         ph,
  input  logic [CW-1:0]  cnt,
  input  logic [NCH-1:0] word,
  output logic           sdo,
  output logic           sck,
  output logic           strobe,
  output logic           clr_n
);
  localparam int BW   = $clog2(NCH);
  localparam int HALF = NCH / 2;

  logic          shifting;
  logic [CW-1:0] half_cnt;
  logic [BW-1:0] bitn, chn;

  always_comb begin
    shifting = (ph == PH_DATA) && (cnt < CW'(2 * NCH));
    half_cnt = cnt >> 1;
    bitn     = half_cnt[BW-1:0];
    if (bitn < BW'(HALF)) chn = BW'(HALF - 1) - bitn;
    else                  chn = BW'(NCH - 1) - (bitn - BW'(HALF));
    sdo    = shifting && word[chn];
    sck    = shifting && cnt[0];
    strobe = (ph == PH_DATA) && (cnt == CW'(STB_AT));
    clr_n  = !((ph == PH_RST) && (cnt == '0));
  end
endmodule

// File: rtl/bcm_led_driver.sv
module bcm_led_driver
  import bcm_led_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int NBITS    = 14,
  parameter int INW      = 16,
  parameter int FIX_CYC  = 68,
  parameter int STB_AT   = 66,
  parameter int RST_CYC  = 4,
  parameter int BASE_CYC = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_addr,
  input  logic [INW-1:0]         wr_data,
  output logic                   sdo,
  output logic                   sck,
  output logic                   strobe,
  output logic                   clr_n
);
  localparam int AW     = $clog2(NCH);
  localparam int IW     = $clog2(NBITS);
  localparam int MAXLEN = FIX_CYC + (BASE_CYC << (NBITS - 1));
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [1:0]     sync_q;
  logic           srst_n;
  phase_t         seq_ph;
  logic [CW-1:0]  seq_cnt;
  logic [IW-1:0]  seq_idx;
  logic           seq_load;
  logic [NCH-1:0] cur_plane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  bcm_phase_seq #(
    .NBITS(NBITS), .FIX_CYC(FIX_CYC), .RST_CYC(RST_CYC),
    .BASE_CYC(BASE_CYC), .CW(CW), .IW(IW)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .ph(seq_ph), .cnt(seq_cnt),
    .idx(seq_idx), .load(seq_load)
  );

  bcm_plane_store #(
    .NCH(NCH), .NBITS(NBITS), .INW(INW), .AW(AW), .IW(IW)
  ) u_store (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(seq_load), .sel(seq_idx), .plane(cur_plane)
  );

  bcm_serial_out #(
    .NCH(NCH), .STB_AT(STB_AT), .CW(CW)
  ) u_ser (
    .ph(seq_ph), .cnt(seq_cnt), .word(cur_plane),
    .sdo(sdo), .sck(sck), .strobe(strobe), .clr_n(clr_n)
  );
endmodule

// File: rtl/bcm_led_checker.sv
module bcm_led_checker #(
  parameter int NBITS = 14,
  parameter int IW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          strobe,
  input logic          clr_n,
  input logic [IW-1:0] idx,
  input logic          load
);
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  a_r4_strobe_no_sck: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !sck);
  a_r8_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> clr_n);
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (!strobe && !sck));
  a_r3_sck_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IW'(NBITS));
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |->
      (idx == (($past(idx) == IW'(NBITS - 1)) ? '0 : $past(idx) + IW'(1))));
  a_r7_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (idx == IW'(NBITS - 1)));
endmodule

bind bcm_led_driver bcm_led_checker #(.NBITS(NBITS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(srst_n), .sck(sck), .strobe(strobe), .clr_n(clr_n),
  .idx(seq_idx), .load(seq_load)
);

// File: tb/sim_bcm_led_driver.sv
module sim_bcm_led_driver;
  localparam int NCH = 32, NBITS = 14, FIX = 68, STB = 66, RST = 4, BASE = 1;
  localparam int NSTB = 43;

  logic clk = 1'b0;
  logic rst_n, wr_en, sdo, sck, strobe, clr_n;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  always #2 clk = ~clk;

  bcm_led_driver u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdo(sdo), .sck(sck), .strobe(strobe), .clr_n(clr_n)
  );

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [15:0] vals [3][NCH];

  // serial stream monitor
  logic        mon_on = 1'b0;
  logic [31:0] asm_w = '0;
  logic [31:0] got [64];
  int          bits_at [64];
  longint      st [64];
  longint      cd [64];
  int          ns = 0, nbits = 0, clr_wide = 0;
  longint      last_clr = -1;
  logic        clr_prev = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!clr_n) begin
        if (!clr_prev) clr_wide = clr_wide + 1;
        last_clr = cyc;
        nbits = 0;
      end
      clr_prev = clr_n;
      if (sck) begin
        if (nbits < 16) asm_w[15 - nbits] = sdo;
        else if (nbits < 32) asm_w[47 - nbits] = sdo;
        nbits = nbits + 1;
      end
      if (strobe && ns < 64) begin
        got[ns] = asm_w;
        bits_at[ns] = nbits;
        st[ns] = cyc;
        cd[ns] = (last_clr < 0) ? -1 : cyc - last_clr;
        ns = ns + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] plane_of(input int set, input int i);
    logic [31:0] w;
    for (int j = 0; j < NCH; j++) w[j] = vals[set][j][i + 2];
    return w;
  endfunction

  task automatic write_set(input int set);
    for (int j = 0; j < NCH; j++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(j); wr_data = vals[set][j];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!sck && !strobe && clr_n, "R9", "idle outputs after reset",
          {sck, strobe, clr_n}, 3'b001);
    end
  endtask

  task automatic t_frame(input int f, input int set, input string req);
    for (int i = 0; i < NBITS; i++) begin
      chk(got[f*NBITS + i] == plane_of(set, i), req, $sformatf("frame %0d plane %0d", f, i),
          got[f*NBITS + i], plane_of(set, i));
      chk(bits_at[f*NBITS + i] == 32, "R3", $sformatf("bits before strobe %0d", f*NBITS + i),
          bits_at[f*NBITS + i], 32);
    end
  endtask

  task automatic t_low_bits;
    for (int i = 0; i < NBITS; i++) begin
      chk(got[NBITS + i][0] == 1'b0, "R2", $sformatf("ch0 low bits plane %0d", i),
          got[NBITS + i][0], 0);
      chk(got[NBITS + i][1] == 1'b1, "R2", $sformatf("ch1 all ones plane %0d", i),
          got[NBITS + i][1], 1);
      chk(got[NBITS + i][31] == (i == NBITS - 1), "R2", $sformatf("ch31 top only plane %0d", i),
          got[NBITS + i][31], (i == NBITS - 1));
    end
  endtask

  task automatic t_timing;
    for (int k = 0; k + 1 < NSTB; k++) begin
      longint exp_gap = FIX + RST + (BASE << (k % NBITS));
      chk(st[k+1] - st[k] == exp_gap, (k % NBITS == NBITS - 1) ? "R6" : "R5",
          $sformatf("strobe gap %0d", k), st[k+1] - st[k], exp_gap);
    end
  endtask

  task automatic t_clear;
    chk(clr_wide == 0, "R8", "clear pulse wider than one cycle", clr_wide, 0);
    chk(cd[0] == -1, "R8", "clear before first strobe", cd[0], -1);
    for (int k = 1; k < NSTB; k++)
      chk(cd[k] == RST + STB, "R8", $sformatf("clear to strobe %0d", k), cd[k], RST + STB);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int j = 0; j < NCH; j++) begin
      vals[0][j] = 16'h0000;
      vals[1][j] = 16'(j * 16'h0931) ^ 16'h5A5C;
      vals[2][j] = 16'(j * 16'h1F3B) + 16'h0101;
    end
    vals[1][0] = 16'h0003; vals[1][1] = 16'hFFFF; vals[1][31] = 16'h8000;
    vals[2][0] = 16'h0004;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    t_reset();
    write_set(1);                       // R1: written during frame 0
    wait (ns >= NBITS + 3);
    write_set(2);                       // R7: written in the middle of frame 1
    wait (ns >= NSTB);
    t_frame(0, 0, "R9");
    t_frame(1, 1, "R7");
    t_frame(2, 2, "R1");
    t_low_bits();
    t_timing();
    t_clear();
    chk(got[3*NBITS] == plane_of(2, 0), "R6", "plane 0 after second wrap",
        got[3*NBITS], plane_of(2, 0));
    finish_run();
  end
endmodule